// File: doc/BRIEF.md
# Command Mailbox with Payload Collector

The block receives adapter control commands through two write-only register offsets. A write to the command offset selects an opcode and starts a fresh collection. Each write to the data offset appends one 32-bit word to a collection buffer. Every opcode has a fixed payload size. When the number of collected bytes reaches that size, the command executes in the same clock edge. The block then registers the result as the command status and returns to an idle reserved opcode with an empty buffer. Commands that need no payload execute on the command write itself.

A dispatch port presents each executed opcode, together with its collected words, for one cycle. Downstream handler logic can act on it from there. The handlers inside the block are minimal. Most return a fixed success or failure. Two handlers carry real logic. Ring setup validates its two page counts and, on success, records that the data rings are valid. Message ring setup depends on a feature-enable input and on whether the data rings are valid. Adapter reset clears both ring flags and emits a one-cycle interrupt-clear pulse.

Opcode map: 0 reserved/unknown, 1 adapter reset, 2 issue (not implemented), 3 ring setup, 4 bus reset, 5 device reset, 6 abort, 7 configuration, 8 unplug (not implemented), 9 message ring setup, 10 end marker.

Top module: `cmd_mailbox`

## Requirements
- R1: A command write whose full 32-bit value is strictly greater than 0 and strictly less than 10 selects that opcode. Any other value, including 0, 10, and values above 10 whose low bits look legal, selects the reserved opcode 0. Opcode 0 needs no payload, so it executes at once and fails.
- R2: A command write clears the word counter and discards any partial collection. If the selected opcode needs payload, the status reads 0xFFFFFFFE (not enough data) in the cycle after the write.
- R3: Each data write stores its word at the current counter index and then increments the counter. Word i of the payload appears in dispatch bits [32*i+31:32*i].
- R4: A command executes when counter×4 reaches its byte size. The sizes in words are: device reset 3, abort 4, configuration 6, ring setup 34, message ring setup 33. After execution the counter is 0 and the opcode is 0. A further data write therefore executes opcode 0 and fails.
- R5: Opcodes 1, 2, 4 and 8 need no payload and execute on the command write.
- R6: Status codes are 0x00000000 for success and 0xFFFFFFFF for failure. The following opcodes fail: configuration, issue, unplug and unknown. The following succeed: bus reset, device reset and abort.
- R7: Ring setup reads word 0 as the request page count and word 1 as the completion page count. It fails if either count is 0 or greater than 8. Otherwise it sets `rings_valid` and succeeds.
- R8: Message ring setup fails if `msg_feature_en` is low. If the feature is enabled and the rings are not valid, it succeeds and changes nothing. If the feature is enabled and the rings are valid, word 0 is the page count: a count of 0 or more than 16 fails, and any other count sets `msg_ring_valid` and succeeds.
- R9: Adapter reset sets status to success, clears `rings_valid` and `msg_ring_valid`, and pulses `intr_clear` for one cycle. It also leaves the reserved opcode with an empty counter.
- R10: Every execution raises `disp_valid` for exactly one cycle, in the cycle after the triggering write. In that cycle `disp_op`, `disp_words` and `cmd_status` show the result of that execution.
- R11: After reset the status is 0, both ring flags are low and `disp_valid` is low. Writes to any offset other than 0x0 (command) and 0x4 (data) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset: 0x0 command, 0x4 data |
| wr_data | input | 32 | Write value |
| msg_feature_en | input | 1 | Enables message ring setup |
| cmd_status | output | 32 | Result of the last command |
| rings_valid | output | 1 | Data rings configured |
| msg_ring_valid | output | 1 | Message ring configured |
| intr_clear | output | 1 | One-cycle pulse on adapter reset |
| disp_valid | output | 1 | An opcode executed in the previous write |
| disp_op | output | 4 | Executed opcode |
| disp_words | output | 1088 | Collected payload, word i at bits [32*i+31:32*i] |

## Verification
Every result depends on a single write edge. The status, the ring flags, `intr_clear` and the dispatch port are all registered at the edge that takes the write, and readiness is decided combinationally from the counter value that includes the new word. The bench therefore drives each write for one edge and samples on the next falling edge, so every check lands exactly one cycle after its stimulus. A scoreboard queue is filled before each payload is sent. The monitor pops one entry per `disp_valid` cycle, so an execution that comes early, late or is missing shows up as a mismatch or as leftover entries.

// File: rtl/cmbx_pkg.sv
`timescale 1ns/1ps
package cmbx_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE          = 4'd0,
    OP_ADAPTER_RESET = 4'd1,
    OP_ISSUE         = 4'd2,
    OP_RINGS         = 4'd3,
    OP_BUS_RESET     = 4'd4,
    OP_DEV_RESET     = 4'd5,
    OP_ABORT         = 4'd6,
    OP_CONFIG        = 4'd7,
    OP_UNPLUG        = 4'd8,
    OP_MSG_RING      = 4'd9,
    OP_END           = 4'd10
  } op_e;

  localparam logic [31:0] ST_OK   = 32'h0000_0000;
  localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;
  localparam logic [31:0] ST_NEED = 32'hFFFF_FFFE;

  // true when a raw command value names a real opcode
  function automatic logic op_legal(input logic [31:0] v);
    return (v > 32'd0) && (v < 32'(OP_END));
  endfunction

  // payload size in bytes for each opcode
  function automatic int unsigned op_bytes(input op_e op, input int unsigned ring_w,
                                           input int unsigned msg_w);
    case (op)
      OP_DEV_RESET: return 12;
      OP_ABORT:     return 16;
      OP_CONFIG:    return 24;
      OP_RINGS:     return ring_w * 4;
      OP_MSG_RING:  return msg_w * 4;
      default:      return 0;
    endcase
  endfunction

  function automatic logic pages_ok(input logic [31:0] n, input int unsigned mx);
    return (n != 32'd0) && (n <= 32'(mx));
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cmbx_collect.sv
`timescale 1ns/1ps
module cmbx_collect
  import cmbx_pkg::*;
#(
  parameter int DEPTH  = 34,
  parameter int CNT_W  = 6,
  parameter int RING_W = 34,
  parameter int MSG_W  = 33
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic                data_wr,
  input  logic [31:0]         wdata,
  output logic                fire,
  output op_e                 fire_op,
  output logic [DEPTH*32-1:0] view
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  op_e              cur_op, nxt_op;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             store;
  logic [31:0]      mem [DEPTH];

  always_comb begin
    nxt_op  = cur_op;
    nxt_cnt = cnt;
    store   = 1'b0;
    if (cmd_wr) begin
      nxt_op  = op_legal(wdata) ? op_e'(wdata[OP_W-1:0]) : OP_NONE;
      nxt_cnt = '0;
    end else if (data_wr && (cnt < DEPTH_C)) begin
      store   = 1'b1;
      nxt_cnt = cnt + 1'b1;
    end
    fire    = (cmd_wr || store) &&
              ((32'(nxt_cnt) * 4) >= op_bytes(nxt_op, RING_W, MSG_W));
    fire_op = nxt_op;
  end

  // payload view including the word being written this cycle
  for (genvar g = 0; g < DEPTH; g++) begin : g_view
    assign view[g*32 +: 32] = (store && (cnt == CNT_W'(g))) ? wdata : mem[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_op <= OP_NONE;
      cnt    <= '0;
    end else if (fire) begin
      cur_op <= OP_NONE;
      cnt    <= '0;
    end else begin
      cur_op <= nxt_op;
      cnt    <= nxt_cnt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)                             mem[i] <= '0;
      else if (store && (cnt == CNT_W'(i)))   mem[i] <= wdata;
    end
  end

  // R4: counter never passes the buffer depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C);
  // R4: an execution returns to the reserved opcode with an empty counter
  a_r4_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cur_op == OP_NONE) && (cnt == '0));
  // R3: a stored word that does not complete a command advances the counter by one
  a_r3_data_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cmd_wr && !fire && (cnt < DEPTH_C)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/cmbx_handle.sv
`timescale 1ns/1ps
module cmbx_handle
  import cmbx_pkg::*;
#(
  parameter int RING_MAX = 8,
  parameter int MSG_MAX  = 16
) (
  input  op_e         op,
  input  logic [63:0] head,
  input  logic        msg_en,
  input  logic        rings_ok,
  output logic [31:0] status,
  output logic        set_rings,
  output logic        set_msg,
  output logic        clear_all
);
  logic [31:0] w0, w1;
  assign w0 = head[31:0];
  assign w1 = head[63:32];

  always_comb begin
    status    = ST_FAIL;
    set_rings = 1'b0;
    set_msg   = 1'b0;
    clear_all = 1'b0;
    case (op)
      OP_ADAPTER_RESET: begin
        status    = ST_OK;
        clear_all = 1'b1;
      end
      OP_BUS_RESET, OP_DEV_RESET, OP_ABORT: status = ST_OK;
      OP_RINGS: begin
        if (pages_ok(w0, RING_MAX) && pages_ok(w1, RING_MAX)) begin
          status    = ST_OK;
          set_rings = 1'b1;
        end
      end
      OP_MSG_RING: begin
        if (!msg_en)                   status = ST_FAIL;
        else if (!rings_ok)            status = ST_OK;
        else if (pages_ok(w0, MSG_MAX)) begin
          status  = ST_OK;
          set_msg = 1'b1;
        end
      end
      default: status = ST_FAIL;
    endcase
  end
endmodule

// File: rtl/cmd_mailbox.sv
`timescale 1ns/1ps
module cmd_mailbox
  import cmbx_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int CMD_OFS        = 0,
  parameter int DATA_OFS       = 4,
  parameter int RING_MAX_PAGES = 8,
  parameter int MSG_MAX_PAGES  = 16,
  localparam int RING_WORDS    = 2 + 4 * RING_MAX_PAGES,
  localparam int MSG_WORDS     = 1 + 2 * MSG_MAX_PAGES,
  localparam int DEPTH         = max3(RING_WORDS, MSG_WORDS, 6)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                msg_feature_en,
  output logic [31:0]         cmd_status,
  output logic                rings_valid,
  output logic                msg_ring_valid,
  output logic                intr_clear,
  output logic                disp_valid,
  output logic [OP_W-1:0]     disp_op,
  output logic [DEPTH*32-1:0] disp_words
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                cmd_wr, data_wr, fire;
  op_e                 fire_op;
  logic [DEPTH*32-1:0] view;
  logic [31:0]         h_status;
  logic                h_set_rings, h_set_msg, h_clear_all;

  assign cmd_wr  = wr_en && (wr_addr == ADDR_W'(CMD_OFS));
  assign data_wr = wr_en && (wr_addr == ADDR_W'(DATA_OFS));

  cmbx_collect #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RING_W(RING_WORDS), .MSG_W(MSG_WORDS)) u_collect (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .wdata(wr_data),
    .fire(fire), .fire_op(fire_op), .view(view)
  );

  cmbx_handle #(.RING_MAX(RING_MAX_PAGES), .MSG_MAX(MSG_MAX_PAGES)) u_handle (
    .op(fire_op), .head(view[63:0]), .msg_en(msg_feature_en), .rings_ok(rings_valid),
    .status(h_status), .set_rings(h_set_rings), .set_msg(h_set_msg), .clear_all(h_clear_all)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_status     <= ST_OK;
      rings_valid    <= 1'b0;
      msg_ring_valid <= 1'b0;
      intr_clear     <= 1'b0;
      disp_valid     <= 1'b0;
      disp_op        <= '0;
      disp_words     <= '0;
    end else begin
      intr_clear <= fire && h_clear_all;
      disp_valid <= fire;
      if (fire) begin
        cmd_status <= h_status;
        disp_op    <= fire_op;
        disp_words <= view;
        if (h_clear_all) begin
          rings_valid    <= 1'b0;
          msg_ring_valid <= 1'b0;
        end else begin
          if (h_set_rings) rings_valid    <= 1'b1;
          if (h_set_msg)   msg_ring_valid <= 1'b1;
        end
      end else if (cmd_wr) begin
        cmd_status <= ST_NEED;
      end
    end
  end

  // R2: a command that still waits for payload reports not-enough-data
  a_r2_need_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !fire) |=> (cmd_status == ST_NEED));
  // R9: the interrupt-clear pulse coincides with a clean adapter state
  a_r9_adapter_clears: assert property (@(posedge clk) disable iff (!rst_n)
    intr_clear |-> (!rings_valid && !msg_ring_valid && (cmd_status == ST_OK)));
  // R8: the message ring is only ever valid on top of valid data rings
  a_r8_msg_needs_rings: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ring_valid |-> rings_valid);
  // R10: a dispatch always carries a final status, never not-enough-data
  a_r10_disp_final: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (cmd_status != ST_NEED));
  // R7: rings become valid only through a ring setup dispatch
  a_r7_rings_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rings_valid) |-> (disp_valid && (disp_op == OP_RINGS)));
endmodule

// File: tb/cmd_mailbox_test.sv
`timescale 1ns/1ps
module cmd_mailbox_test;
  localparam int NW = 34;
  localparam logic [31:0] OK = 32'h0, FL = 32'hFFFF_FFFF, ND = 32'hFFFF_FFFE;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, msg_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd_status;
  logic rings_valid, msg_ring_valid, intr_clear, disp_valid;
  logic [3:0] disp_op;
  logic [NW*32-1:0] disp_words;

  always #2 clk = ~clk;

  cmd_mailbox uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .msg_feature_en(msg_en), .cmd_status(cmd_status), .rings_valid(rings_valid),
    .msg_ring_valid(msg_ring_valid), .intr_clear(intr_clear), .disp_valid(disp_valid),
    .disp_op(disp_op), .disp_words(disp_words)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] op; logic [31:0] st; int idx; logic [31:0] w; string req; } exp_t;
  exp_t sb[$];
  exp_t cur;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_run(input logic [3:0] op, input logic [31:0] st, input int idx,
                            input logic [31:0] w, input string req);
    sb.push_back('{op, st, idx, w, req});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [31:0] d); wr(4'h0, d); endtask
  task automatic dat(input logic [31:0] d); wr(4'h4, d); endtask

  // n payload words: w0, w1, then 0x200+i
  task automatic payload(input int n, input logic [31:0] w0, input logic [31:0] w1);
    for (int i = 0; i < n; i++)
      dat(i == 0 ? w0 : (i == 1 ? w1 : 32'h200 + 32'(i)));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (sb.size() == 0) chk(1'b0, "R10 unexpected dispatch", 32'(disp_op), 32'hx);
      else begin
        cur = sb.pop_front();
        chk(disp_op == cur.op, {cur.req, " opcode"}, 32'(disp_op), 32'(cur.op));
        chk(cmd_status == cur.st, {cur.req, " status"}, cmd_status, cur.st);
        if (cur.idx >= 0)
          chk(disp_words[cur.idx*32 +: 32] == cur.w, {cur.req, " R3 word"},
              disp_words[cur.idx*32 +: 32], cur.w);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_status == OK, "R11 reset status", cmd_status, OK);
    chk(!rings_valid && !msg_ring_valid, "R11 reset flags", {30'd0, rings_valid, msg_ring_valid}, 0);
    chk(!disp_valid, "R11 reset dispatch", 32'(disp_valid), 0);

    // configuration: 6 words, fails
    cmd(7);
    chk(cmd_status == ND, "R2 need data", cmd_status, ND);
    for (int i = 0; i < 5; i++) dat(32'h100 + 32'(i));
    chk(cmd_status == ND, "R4 five of six words", cmd_status, ND);
    wr(4'h8, 32'hDEAD);
    chk(cmd_status == ND && !disp_valid, "R11 other offset ignored", cmd_status, ND);
    expect_run(7, FL, 5, 32'h105, "R6 config");
    dat(32'h105);
    chk(cmd_status == FL, "R6 config status", cmd_status, FL);

    // out-of-range opcodes
    expect_run(0, FL, -1, 0, "R1 opcode 10");
    cmd(10);
    expect_run(0, FL, -1, 0, "R1 opcode 0");
    cmd(0);
    expect_run(0, FL, -1, 0, "R1 opcode high bits");
    cmd(32'hFFFF_FFF3);

    // zero-payload commands
    expect_run(4, OK, -1, 0, "R5 bus reset");
    cmd(4);
    expect_run(2, FL, -1, 0, "R5 issue");
    cmd(2);
    expect_run(8, FL, -1, 0, "R5 unplug");
    cmd(8);

    // device reset, abort
    cmd(5);
    dat(32'hC1); dat(32'hC2);
    chk(cmd_status == ND, "R4 device reset waits", cmd_status, ND);
    expect_run(5, OK, 2, 32'hC3, "R6 device reset");
    dat(32'hC3);
    cmd(6);
    expect_run(6, OK, 0, 32'hA0, "R6 abort");
    for (int i = 0; i < 4; i++) dat(32'hA0 + 32'(i));

    // stray data after completion
    expect_run(0, FL, -1, 0, "R4 stray data");
    dat(32'h55);

    // command write abandons a partial collection
    cmd(6); dat(32'h11); dat(32'h12);
    cmd(7);
    chk(cmd_status == ND, "R2 restart status", cmd_status, ND);
    expect_run(7, FL, 0, 32'hE0, "R2 restart collects anew");
    for (int i = 0; i < 6; i++) dat(32'hE0 + 32'(i));

    // message ring, feature disabled
    msg_en = 1'b0;
    cmd(9);
    expect_run(9, FL, 0, 32'd1, "R8 feature off");
    payload(33, 32'd1, 32'd0);

    // message ring, enabled, rings not valid
    msg_en = 1'b1;
    cmd(9);
    expect_run(9, OK, -1, 0, "R8 no rings");
    payload(33, 32'd4, 32'd0);
    chk(!msg_ring_valid, "R8 no rings leaves flag", 32'(msg_ring_valid), 0);

    // ring setup
    cmd(3);
    expect_run(3, FL, -1, 0, "R7 zero request pages");
    payload(34, 32'd0, 32'd2);
    chk(!rings_valid, "R7 bad keeps invalid", 32'(rings_valid), 0);
    cmd(3);
    expect_run(3, FL, -1, 0, "R7 too many completion pages");
    payload(34, 32'd2, 32'd9);
    cmd(3);
    expect_run(3, OK, 33, 32'h200 + 33, "R7 good setup");
    payload(34, 32'd8, 32'd1);
    chk(rings_valid, "R7 rings valid", 32'(rings_valid), 1);

    // message ring with rings valid
    cmd(9);
    expect_run(9, FL, -1, 0, "R8 too many pages");
    payload(33, 32'd17, 32'd0);
    chk(!msg_ring_valid, "R8 bad count", 32'(msg_ring_valid), 0);
    cmd(9);
    expect_run(9, OK, -1, 0, "R8 good");
    payload(33, 32'd16, 32'd0);
    chk(msg_ring_valid, "R8 msg valid", 32'(msg_ring_valid), 1);

    // adapter reset mid-collection
    cmd(5); dat(32'h1);
    expect_run(1, OK, -1, 0, "R9 adapter reset");
    cmd(1);
    chk(intr_clear, "R9 intr clear pulse", 32'(intr_clear), 1);
    chk(!rings_valid && !msg_ring_valid, "R9 flags cleared", {30'd0, rings_valid, msg_ring_valid}, 0);
    @(negedge clk);
    chk(!intr_clear, "R9 pulse one cycle", 32'(intr_clear), 0);
    expect_run(0, FL, -1, 0, "R9 reserved after reset");
    dat(32'h77);

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R10 missing dispatches", 32'(sb.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule